// File: doc/BRIEF.md
# Platform Management Interrupt Arbiter

This block gathers platform management interrupt events and offers the single most urgent one to a firmware handler. Events reach it from three sources: a dedicated asynchronous pin (which a system may not have), vectored messages from an external interrupt controller, and inter-processor messages. Each event sets a sticky pending bit for its 4-bit vector. The pending bits remain set until the handler clears them one at a time.

The sixteen vectors form three tiers. Vectors 4 to 15 belong to the processor-abstraction firmware. Vectors 1 to 3 belong to the system-abstraction firmware. Vector 0 stands for the pin. The upper tier beats the middle tier, and the middle tier beats the pin. Inside a tier, the larger number wins. Because of this layout, the winner is always the highest-numbered pending bit. The block also reports which firmware layer owns the winner.

Delivery is gated only by the interruption-collection status bit. While that bit is low, new events are still recorded, but no request is raised. The ordinary interrupt-enable bit is not an input of the block, so it cannot affect these events.

Top module: `pmi_arbiter`

## Requirements
- R1: Each vector has its own sticky pending bit, visible on `pend_vec[v]`. The bit is set at the first clock edge that samples an accepted event for `v`. It stays set until a clear removes it.
- R2: When `ext_valid` is high, the bit `ext_vec` is set, for vector values 1 to 15. An external message that carries vector 0 is ignored.
- R3: An inter-processor message (`ipi_valid`) is accepted only when `ipi_mode` equals 3'b010. Any other mode leaves every pending bit unchanged.
- R4: The pin goes through a two-flop synchronizer and a rising-edge detector. A rise sampled at clock edge k sets `pend_vec[0]` at edge k+2. Holding the pin high does not set the bit again after it has been cleared.
- R5: While `pin_present` is 0, pin activity never sets `pend_vec[0]`.
- R6: The winner `win_vec` is the highest-numbered pending vector. This gives the order: 15..4 above 3..1, and 3..1 above 0.
- R7: The owner code `win_owner` is encoded as follows: 2'd3 for the processor-abstraction tier (4..15), 2'd2 for the system tier (1..3), 2'd1 for the pin (0), and 2'd0 when there is no request.
- R8: While `psr_ic` is 0, `req` is 0 and `win_vec`/`win_owner` are 0, but events are still latched. When `psr_ic` returns to 1, they are delivered in the same cycle.
- R9: A `clr_valid` strobe clears only the bit `clr_vec` at the next edge. If an event for the same vector is accepted in that cycle, the bit stays set.
- R10: Events from different sources in the same cycle all latch.
- R11: After reset, all pending bits are 0, `req` is 0, and `win_vec`/`win_owner` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_async | input | 1 | Asynchronous dedicated event pin |
| pin_present | input | 1 | Configuration: 1 if the pin exists |
| ext_valid | input | 1 | External controller message strobe |
| ext_vec | input | 4 | External message vector |
| ipi_valid | input | 1 | Inter-processor message strobe |
| ipi_mode | input | 3 | Inter-processor delivery mode |
| ipi_vec | input | 4 | Inter-processor message vector |
| psr_ic | input | 1 | Interruption-collection status bit (1 = deliver) |
| clr_valid | input | 1 | Clear strobe from the handler |
| clr_vec | input | 4 | Vector to clear |
| pend_vec | output | 16 | Pending bits, one per vector |
| req | output | 1 | Request to the handler |
| win_vec | output | 4 | Winning vector |
| win_owner | output | 2 | Owner code of the winner |

## Verification
A pending bit that is dropped or set wrongly shows up on `pend_vec` one edge after the event or clear that caused it. It also changes `win_vec` in the same cycle whenever the bit is the highest one pending. A wrong synchronizer depth moves the appearance of the pin bit earlier or later than the second edge after the rise. A wrong mask or priority shows up at once on `req`, `win_vec` and `win_owner`, because those outputs are combinational from the pending set.

// File: rtl/pmi_pkg.sv
package pmi_pkg;
   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_PIN  = 2'd1,
      OWN_SYS  = 2'd2,
      OWN_PAL  = 2'd3
   } pmi_owner_e;

   localparam logic [2:0] IPI_PMI_MODE = 3'b010;
endpackage

// File: rtl/pmi_pin_sync.sv
module pmi_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic pin_rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pmi_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain_q[s] <= 1'b0;
         else if (s == 0) chain_q[s] <= pin_async;
         else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign pin_rise = chain_q[STAGES-1] & ~prev_q;

   // R4
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_rise |=> !pin_rise);
endmodule

// File: rtl/pmi_pending.sv
module pmi_pending #(
   parameter int NUM_VEC = 16,
   parameter int VEC_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] set_mask,
   input  logic               clr_valid,
   input  logic [VEC_W-1:0]   clr_vec,
   output logic [NUM_VEC-1:0] pend_q
);
   if (NUM_VEC > (1 << VEC_W)) begin : g_bad_width
      $error("pmi_pending: VEC_W too narrow for NUM_VEC");
   end

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_latch
      logic hit_clr;
      assign hit_clr = clr_valid && (clr_vec == VEC_W'(v));

      always_ff @(posedge clk) begin
         if (!rst_n)           pend_q[v] <= 1'b0;
         else if (set_mask[v]) pend_q[v] <= 1'b1;
         else if (hit_clr)     pend_q[v] <= 1'b0;
      end

      // R1
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q[v] && !hit_clr) |=> pend_q[v]);
      // R9
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_mask[v] |=> pend_q[v]);
   end
endmodule

// File: rtl/pmi_prio_enc.sv
module pmi_prio_enc
   import pmi_pkg::*;
#(
   parameter int NUM_VEC = 16,
   parameter int VEC_W   = 4,
   parameter int PAL_LO  = 4
) (
   input  logic [NUM_VEC-1:0] masked,
   output logic               any,
   output logic [VEC_W-1:0]   win,
   output pmi_owner_e         owner
);
   if (PAL_LO < 2 || PAL_LO >= NUM_VEC) begin : g_bad_band
      $error("pmi_prio_enc: PAL_LO out of range");
   end

   always_comb begin
      any   = 1'b0;
      win   = '0;
      owner = OWN_NONE;
      for (int i = 0; i < NUM_VEC; i++) begin
         if (masked[i]) begin
            any = 1'b1;
            win = VEC_W'(i);
            if (i >= PAL_LO)  owner = OWN_PAL;
            else if (i >= 1)  owner = OWN_SYS;
            else              owner = OWN_PIN;
         end
      end
   end
endmodule

// File: rtl/pmi_arbiter.sv
module pmi_arbiter
   import pmi_pkg::*;
#(
   parameter int VEC_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int PAL_LO      = 4,
   localparam int NUM_VEC    = 1 << VEC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pin_async,
   input  logic               pin_present,
   input  logic               ext_valid,
   input  logic [VEC_W-1:0]   ext_vec,
   input  logic               ipi_valid,
   input  logic [2:0]         ipi_mode,
   input  logic [VEC_W-1:0]   ipi_vec,
   input  logic               psr_ic,
   input  logic               clr_valid,
   input  logic [VEC_W-1:0]   clr_vec,
   output logic [NUM_VEC-1:0] pend_vec,
   output logic               req,
   output logic [VEC_W-1:0]   win_vec,
   output logic [1:0]         win_owner
);
   logic               pin_rise;
   logic [NUM_VEC-1:0] set_mask;
   logic [NUM_VEC-1:0] masked;
   logic               any;
   pmi_owner_e         owner;

   pmi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .pin_rise(pin_rise)
   );

   always_comb begin
      set_mask = '0;
      if (ext_valid && ext_vec != '0) set_mask[ext_vec] = 1'b1;
      if (ipi_valid && ipi_mode == IPI_PMI_MODE && ipi_vec != '0)
         set_mask[ipi_vec] = 1'b1;
      if (pin_rise && pin_present) set_mask[0] = 1'b1;
   end

   pmi_pending #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_mask(set_mask),
      .clr_valid(clr_valid), .clr_vec(clr_vec), .pend_q(pend_vec)
   );

   assign masked = psr_ic ? pend_vec : '0;

   pmi_prio_enc #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .PAL_LO(PAL_LO)) u_enc (
      .masked(masked), .any(any), .win(win_vec), .owner(owner)
   );

   assign req       = any;
   assign win_owner = owner;

   // R8
   mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !psr_ic |-> (!req && win_owner == 2'd0));
   // R6
   win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> pend_vec[win_vec]);
   // R7
   owner_pal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && win_vec >= VEC_W'(PAL_LO)) |-> win_owner == 2'd3);
   // R5
   pin_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_vec[0]) |-> $past(pin_present));
endmodule

// File: tb/pmi_arbiter_tb.sv
module pmi_arbiter_tb;
   logic clk = 0;
   logic rst_n = 0;
   logic pin_async = 0, pin_present = 0;
   logic ext_valid = 0; logic [3:0] ext_vec = 0;
   logic ipi_valid = 0; logic [2:0] ipi_mode = 0; logic [3:0] ipi_vec = 0;
   logic psr_ic = 1;
   logic clr_valid = 0; logic [3:0] clr_vec = 0;
   logic [15:0] pend_vec;
   logic req;
   logic [3:0] win_vec;
   logic [1:0] win_owner;
   int checks = 0, fails = 0;

   always #5 clk = ~clk;

   pmi_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .pin_present(pin_present),
      .ext_valid(ext_valid), .ext_vec(ext_vec), .ipi_valid(ipi_valid),
      .ipi_mode(ipi_mode), .ipi_vec(ipi_vec), .psr_ic(psr_ic),
      .clr_valid(clr_valid), .clr_vec(clr_vec), .pend_vec(pend_vec),
      .req(req), .win_vec(win_vec), .win_owner(win_owner)
   );

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_ext(logic [3:0] v);
      ext_valid = 1; ext_vec = v; tick(); ext_valid = 0;
   endtask

   task automatic clear(logic [3:0] v);
      clr_valid = 1; clr_vec = v; tick(); clr_valid = 0;
   endtask

   task automatic clear_all();
      for (int i = 0; i < 16; i++) clear(4'(i));
   endtask

   task automatic t_reset();
      chk("R11 pend", int'(pend_vec), 0);
      chk("R11 req", int'(req), 0);
      chk("R11 win", int'(win_vec), 0);
      chk("R11 owner", int'(win_owner), 0);
   endtask

   task automatic t_priority();
      send_ext(4'd2);
      chk("R2 pend2", int'(pend_vec), 16'h0004);
      chk("R7 sys owner", int'(win_owner), 2);
      send_ext(4'd7);
      chk("R6 pal beats sys", int'(win_vec), 7);
      chk("R7 pal owner", int'(win_owner), 3);
      tick();
      chk("R1 sticky", int'(pend_vec), 16'h0084);
      clear(4'd7);
      chk("R6 falls to sys", int'(win_vec), 2);
      send_ext(4'd3);
      chk("R6 higher in band", int'(win_vec), 3);
      send_ext(4'd15);
      send_ext(4'd4);
      chk("R6 15 over 4", int'(win_vec), 15);
      clear_all();
   endtask

   task automatic t_ipi();
      ipi_valid = 1; ipi_mode = 3'b010; ipi_vec = 4'd9; tick();
      chk("R3 mode 010 accepted", int'(pend_vec), 16'h0200);
      ipi_mode = 3'b011; ipi_vec = 4'd10; tick();
      ipi_mode = 3'b000; ipi_vec = 4'd11; tick();
      ipi_valid = 0;
      chk("R3 other modes ignored", int'(pend_vec), 16'h0200);
      clear_all();
   endtask

   task automatic t_pin();
      pin_present = 1;
      pin_async = 1;
      tick(); tick();
      chk("R4 not yet after 2 edges", int'(pend_vec[0]), 0);
      tick();
      chk("R4 set at 3rd edge", int'(pend_vec[0]), 1);
      chk("R7 pin owner", int'(win_owner), 1);
      chk("R6 pin vec", int'(win_vec), 0);
      clear(4'd0);
      tick(); tick();
      chk("R4 level no reset", int'(pend_vec[0]), 0);
      pin_async = 0; tick(); tick(); tick();
      pin_present = 0;
      pin_async = 1; tick(); tick(); tick(); tick();
      pin_async = 0; tick(); tick(); tick(); tick();
      chk("R5 absent pin ignored", int'(pend_vec), 0);
      send_ext(4'd1);
      pin_present = 1; pin_async = 1; tick(); tick(); tick();
      chk("R6 sys over pin", int'(win_vec), 1);
      pin_async = 0;
      clear_all();
      pin_present = 0;
   endtask

   task automatic t_mask();
      psr_ic = 0;
      send_ext(4'd12);
      chk("R8 latched while masked", int'(pend_vec), 16'h1000);
      chk("R8 req masked", int'(req), 0);
      chk("R8 win masked", int'(win_vec), 0);
      chk("R8 owner masked", int'(win_owner), 0);
      psr_ic = 1; #1;
      chk("R8 delivered on unmask", int'(req), 1);
      chk("R8 win on unmask", int'(win_vec), 12);
      clear_all();
   endtask

   task automatic t_clear();
      send_ext(4'd5);
      send_ext(4'd6);
      clr_valid = 1; clr_vec = 4'd5; ext_valid = 1; ext_vec = 4'd5; tick();
      clr_valid = 0; ext_valid = 0;
      chk("R9 set beats clear", int'(pend_vec), 16'h0060);
      clear(4'd5);
      chk("R9 clears one", int'(pend_vec), 16'h0040);
      clear_all();
   endtask

   task automatic t_vec0_msg();
      send_ext(4'd0);
      ipi_valid = 1; ipi_mode = 3'b010; ipi_vec = 4'd0; tick(); ipi_valid = 0;
      chk("R2 message vector 0 ignored", int'(pend_vec), 0);
   endtask

   task automatic t_simul();
      ext_valid = 1; ext_vec = 4'd8; ipi_valid = 1; ipi_mode = 3'b010; ipi_vec = 4'd1;
      tick();
      ext_valid = 0; ipi_valid = 0;
      chk("R10 both latch", int'(pend_vec), 16'h0102);
      clear_all();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      tick(); tick();
      rst_n = 1; tick();
      t_reset();
      t_priority();
      t_ipi();
      t_pin();
      t_mask();
      t_clear();
      t_vec0_msg();
      t_simul();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule